// File: doc/BRIEF.md
# Scrambled-RAM key renewal and fill sequencer

This block sits beside a scrambled on-chip RAM and handles two requests from a control register: renewing the scrambling key and filling the whole RAM with pseudo-random data. A renewal strobe raises a key request toward a key-delivery agent. The agent answers with a one-cycle acknowledge and a nonce. The low 32 bits of that nonce are kept as the seed for a 32-bit LFSR.

A fill strobe starts a walk over every RAM address. Each address gets one LFSR word per cycle. The walk only runs once the key is valid. When both strobes arrive in the same cycle, the key exchange completes first and the fill then uses the new seed. A strobe that arrives while its own operation, or a blocking one, is already outstanding is dropped. While the key is not valid or a fill is outstanding, the block tells the bus side to hold off normal RAM traffic.

Top module: `mem_init_seq`

## Requirements
- R1: After reset, key_req_o, key_valid_o, init_done_o, init_done_pulse_o and mem_we_o are 0 and bus_block_o is 1.
- R2: An accepted renew strobe sets key_req_o from the next cycle and holds it until a cycle with key_ack_i high. key_valid_o is 0 from the cycle after the strobe. It becomes 1 in the cycle after the acknowledge, and key_req_o drops in that same cycle.
- R3: A renew strobe is ignored while a key request is outstanding. After the acknowledge, no second request appears.
- R4: A renew strobe is ignored while a fill is outstanding. No key request is raised and key_valid_o stays 1.
- R5: A fill writes on DEPTH consecutive cycles. Addresses run from 0 upward by 1. The first word is the seed. Each following word is the previous word v stepped as (v >> 1) XOR (0x80200003 if bit 0 of v is 1, else 0).
- R6: The seed is bits 31:0 of the nonce taken with the most recent acknowledge. If those bits are all zero, the seed is 0x6A09E667 instead.
- R7: Renew and fill strobes in the same cycle raise the key request first. No RAM write occurs before the cycle after the acknowledge. The fill is then seeded from that acknowledge's nonce.
- R8: A fill strobe is ignored while a fill is outstanding. The walk neither restarts nor changes, and exactly DEPTH writes occur in total.
- R9: In the cycle after the write to address DEPTH-1, init_done_pulse_o is 1 for exactly one cycle and init_done_o becomes 1 and holds. init_done_o returns to 0 in the cycle after an accepted fill strobe.
- R10: bus_block_o is 1 whenever the key is not valid or a fill is outstanding, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| renew_wr_i | input | 1 | One-cycle strobe: request a new key |
| init_wr_i | input | 1 | One-cycle strobe: request a RAM fill |
| key_req_o | output | 1 | Key request to the delivery agent, held until acknowledged |
| key_ack_i | input | 1 | One-cycle key acknowledge |
| nonce_i | input | NONCE_W | Nonce valid with key_ack_i |
| mem_we_o | output | 1 | RAM write enable during a fill |
| mem_addr_o | output | AW | RAM write address |
| mem_wdata_o | output | 32 | RAM write data from the LFSR |
| bus_block_o | output | 1 | Hold off normal RAM transactions |
| key_valid_o | output | 1 | Current key is valid |
| init_done_o | output | 1 | Sticky fill-complete status |
| init_done_pulse_o | output | 1 | One-cycle fill-complete pulse |

## Verification
The hardest cases to reach are strobes that land while another operation is still outstanding. Examples are a fill strobe in the middle of a walk, a renew strobe during a walk, and both strobes in one cycle while the key agent is still slow to answer. The bench gets there with a key agent of fixed latency and by timing strobes a known number of cycles into each operation. A reference LFSR in the bench follows every write on the fly, so a restarted or reseeded walk shows up as a data or address mismatch.

// File: rtl/mis_pkg.sv
package mis_pkg;
  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
    return (v >> 1) ^ (v[0] ? LFSR_TAPS : '0);
  endfunction
endpackage

// File: rtl/mis_req_ctrl.sv
module mis_req_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic renew_wr_i,
  input  logic init_wr_i,
  input  logic key_ack_i,
  input  logic last_i,
  output logic key_pend_o,
  output logic init_pend_o,
  output logic key_valid_o,
  output logic init_done_o,
  output logic done_pulse_o,
  output logic init_fire_o,
  output logic ack_take_o,
  output logic run_o
);
  logic key_pend_q, key_pend_d;
  logic init_pend_q, init_pend_d;
  logic key_valid_q, key_valid_d;
  logic done_q, done_d;
  logic pulse_q, pulse_d;
  logic key_fire, finish;

  // A new renewal is refused while either operation is outstanding
  assign key_fire    = renew_wr_i && !key_pend_q && !init_pend_q;
  assign init_fire_o = init_wr_i && !init_pend_q;
  assign ack_take_o  = key_ack_i && key_pend_q;
  assign run_o       = init_pend_q && key_valid_q;
  assign finish      = run_o && last_i;

  always_comb begin
    key_pend_d  = key_pend_q;
    key_valid_d = key_valid_q;
    init_pend_d = init_pend_q;
    done_d      = done_q;
    if (key_fire) begin
      key_pend_d  = 1'b1;
      key_valid_d = 1'b0;
    end else if (ack_take_o) begin
      key_pend_d  = 1'b0;
      key_valid_d = 1'b1;
    end
    if (finish) begin
      init_pend_d = 1'b0;
      done_d      = 1'b1;
    end else if (init_fire_o) begin
      init_pend_d = 1'b1;
      done_d      = 1'b0;
    end
    pulse_d = finish;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_pend_q  <= 1'b0;
      key_valid_q <= 1'b0;
      init_pend_q <= 1'b0;
      done_q      <= 1'b0;
      pulse_q     <= 1'b0;
    end else begin
      key_pend_q  <= key_pend_d;
      key_valid_q <= key_valid_d;
      init_pend_q <= init_pend_d;
      done_q      <= done_d;
      pulse_q     <= pulse_d;
    end
  end

  assign key_pend_o   = key_pend_q;
  assign init_pend_o  = init_pend_q;
  assign key_valid_o  = key_valid_q;
  assign init_done_o  = done_q;
  assign done_pulse_o = pulse_q;
endmodule

// File: rtl/mis_addr_cnt.sv
module mis_addr_cnt #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  logic [AW-1:0] cnt_q, cnt_d;

  assign last_o = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (adv_i)  cnt_d = last_o ? '0 : cnt_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign addr_o = cnt_q;
endmodule

// File: rtl/mis_lfsr.sv
module mis_lfsr
  import mis_pkg::*;
#(
  parameter logic [LFSR_W-1:0] ZERO_SEED = 32'h6A09_E667
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] st_q, st_d, seed_fix;

  // An all-zero state would lock up, so swap in a fixed constant
  assign seed_fix = (seed_i == '0) ? ZERO_SEED : seed_i;

  always_comb begin
    st_d = st_q;
    if (load_i)      st_d = seed_fix;
    else if (step_i) st_d = lfsr_step(st_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ZERO_SEED;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/mem_init_seq.sv
module mem_init_seq
  import mis_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned NONCE_W = 64,
  parameter logic [LFSR_W-1:0] ZERO_SEED = 32'h6A09_E667,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               renew_wr_i,
  input  logic               init_wr_i,
  output logic               key_req_o,
  input  logic               key_ack_i,
  input  logic [NONCE_W-1:0] nonce_i,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [LFSR_W-1:0]  mem_wdata_o,
  output logic               bus_block_o,
  output logic               key_valid_o,
  output logic               init_done_o,
  output logic               init_done_pulse_o
);
  logic key_pend, init_pend, key_valid, init_fire, ack_take, run, last;
  logic lfsr_load;
  logic [LFSR_W-1:0] seed_q, seed_d, load_val;

  mis_req_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .renew_wr_i   (renew_wr_i),
    .init_wr_i    (init_wr_i),
    .key_ack_i    (key_ack_i),
    .last_i       (last),
    .key_pend_o   (key_pend),
    .init_pend_o  (init_pend),
    .key_valid_o  (key_valid),
    .init_done_o  (init_done_o),
    .done_pulse_o (init_done_pulse_o),
    .init_fire_o  (init_fire),
    .ack_take_o   (ack_take),
    .run_o        (run)
  );

  mis_addr_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (init_fire),
    .adv_i   (run),
    .addr_o  (mem_addr_o),
    .last_o  (last)
  );

  // Seed register: low nonce bits of the latest accepted acknowledge
  assign seed_d = ack_take ? nonce_i[LFSR_W-1:0] : seed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seed_q <= '0;
    else         seed_q <= seed_d;
  end

  // Reload on an accepted fill, and again on acknowledge so a fill that
  // waits behind a key exchange picks up the fresh nonce
  assign lfsr_load = init_fire || ack_take;
  assign load_val  = ack_take ? nonce_i[LFSR_W-1:0] : seed_q;

  mis_lfsr #(.ZERO_SEED(ZERO_SEED)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (lfsr_load),
    .seed_i  (load_val),
    .step_i  (run),
    .state_o (mem_wdata_o)
  );

  assign key_req_o   = key_pend;
  assign key_valid_o = key_valid;
  assign mem_we_o    = run;
  assign bus_block_o = !key_valid || init_pend;
endmodule

// File: rtl/mis_chk.sv
module mis_chk #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          key_req_o,
  input logic          key_ack_i,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          bus_block_o,
  input logic          key_valid_o,
  input logic          init_done_pulse_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R2
  req_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o && !key_ack_i |=> key_req_o);

  // R2
  req_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_req_o |-> !key_valid_o);

  // R7
  write_keyed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> key_valid_o && !key_req_o);

  // R10
  write_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> bus_block_o);

  // R5
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && (mem_addr_o != '0) |->
      $past(mem_we_o) && (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));

  // R9
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && (mem_addr_o == LAST) |=> init_done_pulse_o && !mem_we_o);

  // R9
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_pulse_o |=> !init_done_pulse_o);
endmodule

bind mem_init_seq mis_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .key_req_o         (key_req_o),
  .key_ack_i         (key_ack_i),
  .mem_we_o          (mem_we_o),
  .mem_addr_o        (mem_addr_o),
  .bus_block_o       (bus_block_o),
  .key_valid_o       (key_valid_o),
  .init_done_pulse_o (init_done_pulse_o)
);

// File: tb/sim_mem_init_seq.sv
`timescale 1ns/1ps
module sim_mem_init_seq;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned AW = 4;
  localparam int unsigned NONCE_W = 64;
  localparam int ACK_LAT = 7;
  localparam logic [31:0] ALT_SEED = 32'h6A09_E667;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic renew_wr_i = 1'b0, init_wr_i = 1'b0, key_ack_i = 1'b0;
  logic [NONCE_W-1:0] nonce_i = '0;
  logic key_req_o, mem_we_o, bus_block_o, key_valid_o, init_done_o, init_done_pulse_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o;

  int total = 0, bad = 0, cycles = 0;
  int req_cnt = 0, wr_cnt = 0, seq_err = 0, lat = 0;
  logic req_prev = 1'b0;
  logic [NONCE_W-1:0] next_nonce = '0;
  logic [AW-1:0] exp_addr = '0;
  logic [31:0] exp_data = '0;

  always #2.5 clk_i = ~clk_i;

  mem_init_seq #(.DEPTH(DEPTH), .NONCE_W(NONCE_W)) u0 (.*);

  function automatic logic [31:0] ref_step(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [31:0] ref_seed(input logic [NONCE_W-1:0] n);
    return (n[31:0] == 32'h0) ? ALT_SEED : n[31:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Key agent with fixed latency, and write monitor
  always @(negedge clk_i) begin
    cycles++;
    if (key_req_o && !req_prev) req_cnt++;
    req_prev = key_req_o;
    if (key_ack_i) key_ack_i = 1'b0;
    else if (key_req_o) begin
      if (lat == 0) lat = ACK_LAT;
      else begin
        lat--;
        if (lat == 0) begin
          key_ack_i = 1'b1;
          nonce_i = next_nonce;
        end
      end
    end
    if (mem_we_o) begin
      if (mem_addr_o != exp_addr || mem_wdata_o != exp_data) seq_err++;
      exp_addr = exp_addr + 1'b1;
      exp_data = ref_step(exp_data);
      wr_cnt++;
    end
    if (cycles > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic strobe(input bit rn, input bit in);
    @(negedge clk_i);
    renew_wr_i = rn;
    init_wr_i = in;
    @(negedge clk_i);
    renew_wr_i = 1'b0;
    init_wr_i = 1'b0;
  endtask

  task automatic wait_valid();
    while (!key_valid_o) @(negedge clk_i);
  endtask

  task automatic arm_fill(input logic [NONCE_W-1:0] n);
    exp_addr = '0;
    exp_data = ref_seed(n);
    wr_cnt = 0;
    seq_err = 0;
  endtask

  task automatic finish_fill(input string tag);
    while (!init_done_pulse_o) @(negedge clk_i);
    chk(wr_cnt == DEPTH, {tag, " R5 write count"}, wr_cnt, DEPTH);
    chk(seq_err == 0, {tag, " R5 addr/data sequence"}, seq_err, 0);
    chk(init_done_o, "R9 sticky set with pulse", init_done_o, 1);
    @(negedge clk_i);
    chk(!init_done_pulse_o, "R9 pulse one cycle", init_done_pulse_o, 0);
    chk(init_done_o && !bus_block_o, "R10 unblocked after fill", bus_block_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(!key_req_o && !key_valid_o && !init_done_o && !init_done_pulse_o && !mem_we_o,
        "R1 reset outputs", {key_req_o, key_valid_o, init_done_o, init_done_pulse_o, mem_we_o}, 0);
    chk(bus_block_o, "R1 bus blocked", bus_block_o, 1);

    // R2 / R3: renewal, with a second strobe while outstanding
    next_nonce = 64'h1234_5678_9ABC_DEF1;
    strobe(1'b1, 1'b0);
    chk(key_req_o && !key_valid_o, "R2 request raised", {key_req_o, key_valid_o}, 2'b10);
    chk(bus_block_o, "R10 blocked during key wait", bus_block_o, 1);
    strobe(1'b1, 1'b0);
    wait_valid();
    chk(!key_req_o, "R2 request dropped with valid", key_req_o, 0);
    chk(!bus_block_o, "R10 unblocked with valid key", bus_block_o, 0);
    repeat (ACK_LAT + 3) @(negedge clk_i);
    chk(req_cnt == 1 && !key_req_o, "R3 repeat renew ignored", req_cnt, 1);

    // R5 / R6 / R8 / R4: fill with stray strobes mid-walk
    arm_fill(next_nonce);
    strobe(1'b0, 1'b1);
    chk(bus_block_o && !init_done_o, "R10 blocked during fill", bus_block_o, 1);
    repeat (3) @(negedge clk_i);
    strobe(1'b0, 1'b1);
    strobe(1'b1, 1'b0);
    @(negedge clk_i);
    chk(!key_req_o && key_valid_o, "R4 renew ignored in fill", {key_req_o, key_valid_o}, 2'b01);
    finish_fill("R8 restrike");
    chk(req_cnt == 1, "R4 no extra key request", req_cnt, 1);

    // R7: both strobes together, over several nonces
    for (int i = 0; i < 3; i++) begin
      next_nonce = {32'hC0DE_0000 + 32'(i), 32'h0F0F_1357 * 32'(i + 3)};
      arm_fill(next_nonce);
      strobe(1'b1, 1'b1);
      chk(key_req_o && !init_done_o, "R7 key first, R9 done cleared", {key_req_o, init_done_o}, 2'b10);
      chk(wr_cnt == 0, "R7 no write before ack", wr_cnt, 0);
      finish_fill("R7");
      chk(req_cnt == 2 + i, "R7 one request per pair", req_cnt, 2 + i);
    end

    // R6: zero seed bits replaced by the fixed constant
    next_nonce = 64'hFEED_BEEF_0000_0000;
    strobe(1'b1, 1'b0);
    wait_valid();
    arm_fill(next_nonce);
    strobe(1'b0, 1'b1);
    chk(mem_we_o && mem_wdata_o == ALT_SEED, "R6 zero seed swapped", mem_wdata_o, ALT_SEED);
    finish_fill("R6");

    // R6: a fill without a fresh key reuses the last nonce
    arm_fill(next_nonce);
    strobe(1'b0, 1'b1);
    finish_fill("R6 reuse");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule